// File: doc/BRIEF.md
# Circular Floating-Point Register Stack

This block holds eight 64-bit floating-point register entries that are addressed through a three-bit top pointer. The pointer wraps around. Each entry carries a one-bit tag that marks it empty or full. Each cycle a controller issues at most one operation:

- **push** and **pop** move the pointer;
- **read**, **write** and **read-modify-write** reach the entry `(top + slot) mod 8`;
- **examine** inspects an entry whatever its tag;
- **store-top** copies slot 0 into slot `slot`;
- **tag write**, **load top** and **clear** are the housekeeping operations that software-visible state restore needs.

The block does no arithmetic. Every operation resolves in the cycle it is issued. Its result appears on registered outputs one clock later:

- returned data, together with the tag of the entry that was read;
- or exactly one of two fault pulses:
  - empty-register fault, for a read or modify of an empty entry;
  - full-register fault, for a pure write into a full entry.

A faulting operation changes nothing. Two operation kinds are exempt from the fault rules:

- examine never faults;
- store-top never raises the full fault on its destination.

The operation kinds are the only sequencing the block has, and they are decoded in one cycle. Their names are NOP, PUSH, POP, READ, WRITE, RMW, EXAM, STORE, TAGSET, SETTOP and CLEAR. Each one either completes, fault-free, or faults. There is no multi-cycle state.

Top module: `fpstk_rstack`

## Requirements
- R1: After reset every tag is empty (`tags_out` = 0), `top_out` = 0, and `rd_valid`, `fault_empty` and `fault_full` are low.
- R2: PUSH (op 1) first computes `t = (top - 1) mod 8`. If entry t is full it raises `fault_full`. Otherwise it writes `wr_data` to entry t, marks t full and sets top to t.
- R3: POP (op 2) on a full top entry returns that entry's data with `rd_valid`, marks it empty and sets top to `(top + 1) mod 8`.
- R4: READ (op 3), WRITE (op 4), RMW (op 5), EXAM (op 6) and the destination of STORE (op 7) all address physical entry `(top + op_slot) mod 8`.
- R5: A READ or a POP whose selected entry is empty raises `fault_empty` and returns no data.
- R6: WRITE into an empty entry stores `wr_data` and marks the entry full. WRITE into a full entry raises `fault_full`.
- R7: RMW of a full entry returns its old data and stores `wr_data`. RMW of an empty entry raises `fault_empty`.
- R8: EXAM returns the entry's data and, on `rd_full`, its tag (1 = full), whatever the tag state. It never raises a fault.
- R9: STORE copies entry top into the destination and marks the destination full, with no full fault even if the destination is already full. If entry top is empty it raises `fault_empty`.
- R10: A faulting operation leaves every data entry, every tag and the top pointer unchanged. Exactly one of `rd_valid`, `fault_empty` and `fault_full` is high in any cycle, or none is. A fault pulse lasts one cycle, and a following NOP (op 0) shows no fault.
- R11: TAGSET (op 8) writes `tag_in` to the physical entry `op_slot`. SETTOP (op 9) loads top from `top_in[2:0]`; bits 31:3 of `top_in` are ignored.
- R12: CLEAR (op 10) empties every tag and sets top to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_code | input | 4 | Operation kind, encoded as in R2 to R12 (11 to 15 act as NOP) |
| op_slot | input | 3 | Relative slot, or physical entry for TAGSET |
| wr_data | input | 64 | Data for PUSH, WRITE and RMW |
| tag_in | input | 1 | Tag value for TAGSET (1 = full) |
| top_in | input | 32 | Pointer value for SETTOP; only the low 3 bits are used |
| rd_data | output | 64 | Returned entry data, meaningful when `rd_valid` is high |
| rd_valid | output | 1 | One-cycle pulse: the operation returned data |
| rd_full | output | 1 | Tag of the returned entry |
| fault_empty | output | 1 | One-cycle empty-register fault pulse |
| fault_full | output | 1 | One-cycle full-register fault pulse |
| top_out | output | 3 | Current top pointer |
| tags_out | output | 8 | Current tags, bit n for physical entry n |

## Verification
Directed sequences cover the pointer corners:

- Filling all eight entries and then pushing once more separates correct wrap-around from a missing full check.
- Draining to empty and then popping, reading, modifying and storing separates the empty-fault paths from the fault-exempt EXAM.
- Storing slot 0 onto a full slot tells the store exemption apart from an ordinary WRITE.
- Loading top with garbage in the upper bits shows whether those bits are masked.

A seeded random mix of all eleven operation kinds then runs from arbitrary pointer and tag states. Every result is compared with a bench model, which exposes any error in relative addressing or in tag updates at every offset.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_PUSH   = 4'd1,
        OP_POP    = 4'd2,
        OP_READ   = 4'd3,
        OP_WRITE  = 4'd4,
        OP_RMW    = 4'd5,
        OP_EXAM   = 4'd6,
        OP_STORE  = 4'd7,
        OP_TAGSET = 4'd8,
        OP_SETTOP = 4'd9,
        OP_CLEAR  = 4'd10
    } stk_op_e;

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import fpstk_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int PTR_W   = $clog2(DEPTH),
    parameter int TOPIN_W = 32
) (
    input  logic               op_valid,
    input  logic [3:0]         op_code,
    input  logic [PTR_W-1:0]   op_slot,
    input  logic               tag_in,
    input  logic [TOPIN_W-1:0] top_in,
    input  logic [PTR_W-1:0]   top_q,
    input  logic [DEPTH-1:0]   tags_q,
    output logic [PTR_W-1:0]   src_idx,
    output logic [PTR_W-1:0]   tgt_idx,
    output logic               data_we,
    output logic               copy_sel,
    output logic               tag_we,
    output logic               tag_wv,
    output logic               top_we,
    output logic [PTR_W-1:0]   top_nxt,
    output logic               clear_all,
    output logic               ret_data,
    output logic               flt_empty,
    output logic               flt_full
);

    localparam logic [PTR_W-1:0] STEP = PTR_W'(1);

    logic [PTR_W-1:0] rel_idx;
    logic [PTR_W-1:0] below_top;
    logic [PTR_W-1:0] above_top;
    logic             unused_top_hi;
    stk_op_e          op;

    assign rel_idx       = top_q + op_slot;
    assign below_top     = top_q - STEP;
    assign above_top     = top_q + STEP;
    assign unused_top_hi = ^top_in[TOPIN_W-1:PTR_W];
    assign op            = op_valid ? stk_op_e'(op_code) : OP_NOP;

    always_comb begin
        src_idx   = rel_idx;
        tgt_idx   = rel_idx;
        data_we   = 1'b0;
        copy_sel  = 1'b0;
        tag_we    = 1'b0;
        tag_wv    = 1'b0;
        top_we    = 1'b0;
        top_nxt   = top_q;
        clear_all = 1'b0;
        ret_data  = 1'b0;
        flt_empty = 1'b0;
        flt_full  = 1'b0;
        unique case (op)
            OP_PUSH: begin
                tgt_idx = below_top;
                if (tags_q[below_top]) begin
                    flt_full = 1'b1;
                end else begin
                    data_we = 1'b1;
                    tag_we  = 1'b1;
                    tag_wv  = 1'b1;
                    top_we  = 1'b1;
                    top_nxt = below_top;
                end
            end
            OP_POP: begin
                src_idx = top_q;
                tgt_idx = top_q;
                if (!tags_q[top_q]) begin
                    flt_empty = 1'b1;
                end else begin
                    ret_data = 1'b1;
                    tag_we   = 1'b1;
                    tag_wv   = 1'b0;
                    top_we   = 1'b1;
                    top_nxt  = above_top;
                end
            end
            OP_READ: begin
                if (!tags_q[rel_idx]) flt_empty = 1'b1;
                else                  ret_data  = 1'b1;
            end
            OP_WRITE: begin
                if (tags_q[rel_idx]) begin
                    flt_full = 1'b1;
                end else begin
                    data_we = 1'b1;
                    tag_we  = 1'b1;
                    tag_wv  = 1'b1;
                end
            end
            OP_RMW: begin
                if (!tags_q[rel_idx]) begin
                    flt_empty = 1'b1;
                end else begin
                    ret_data = 1'b1;
                    data_we  = 1'b1;
                end
            end
            OP_EXAM: begin
                ret_data = 1'b1;
            end
            OP_STORE: begin
                src_idx = top_q;
                if (!tags_q[top_q]) begin
                    flt_empty = 1'b1;
                end else begin
                    ret_data = 1'b1;
                    data_we  = 1'b1;
                    copy_sel = 1'b1;
                    tag_we   = 1'b1;
                    tag_wv   = 1'b1;
                end
            end
            OP_TAGSET: begin
                tgt_idx = op_slot;
                tag_we  = 1'b1;
                tag_wv  = tag_in;
            end
            OP_SETTOP: begin
                top_we  = 1'b1;
                top_nxt = top_in[PTR_W-1:0];
            end
            OP_CLEAR: begin
                clear_all = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/stk_tags.sv
module stk_tags #(
    parameter int DEPTH = 8,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_all,
    input  logic             tag_we,
    input  logic [PTR_W-1:0] tag_idx,
    input  logic             tag_wv,
    input  logic             top_we,
    input  logic [PTR_W-1:0] top_nxt,
    output logic [DEPTH-1:0] tags_q,
    output logic [PTR_W-1:0] top_q
);

    always_ff @(posedge clk) begin
        if (rst || clear_all) top_q <= '0;
        else if (top_we)      top_q <= top_nxt;
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_tag
        always_ff @(posedge clk) begin
            if (rst || clear_all)
                tags_q[e] <= 1'b0;
            else if (tag_we && tag_idx == PTR_W'(e))
                tags_q[e] <= tag_wv;
        end
    end

    // R12
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        clear_all |=> (tags_q == '0 && top_q == '0));

    // R11
    tag_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (tag_we && !clear_all) |=> tags_q[$past(tag_idx)] == $past(tag_wv));

endmodule

// File: rtl/stk_regs.sv
module stk_regs #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 64,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              data_we,
    input  logic              copy_sel,
    input  logic [PTR_W-1:0]  tgt_idx,
    input  logic [PTR_W-1:0]  src_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] entry_q [DEPTH];
    logic [DATA_W-1:0] wr_val;

    assign rd_word = entry_q[src_idx];
    assign wr_val  = copy_sel ? rd_word : wr_data;

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                entry_q[e] <= '0;
            else if (data_we && tgt_idx == PTR_W'(e))
                entry_q[e] <= wr_val;
        end
    end

    // R6
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (data_we && !copy_sel) |=> entry_q[$past(tgt_idx)] == $past(wr_data));

    // R9
    copy_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (data_we && copy_sel) |=> entry_q[$past(tgt_idx)] == $past(entry_q[src_idx]));

endmodule

// File: rtl/fpstk_rstack.sv
module fpstk_rstack
    import fpstk_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int DATA_W  = 64,
    parameter int TOPIN_W = 32,
    parameter int PTR_W   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    input  logic [3:0]         op_code,
    input  logic [PTR_W-1:0]   op_slot,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               tag_in,
    input  logic [TOPIN_W-1:0] top_in,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_valid,
    output logic               rd_full,
    output logic               fault_empty,
    output logic               fault_full,
    output logic [PTR_W-1:0]   top_out,
    output logic [DEPTH-1:0]   tags_out
);

    localparam logic [PTR_W-1:0] STEP = PTR_W'(1);

    logic [PTR_W-1:0]  src_idx, tgt_idx, top_nxt, top_q;
    logic [DEPTH-1:0]  tags_q;
    logic              data_we, copy_sel, tag_we, tag_wv, top_we;
    logic              clear_all, ret_data, flt_empty, flt_full;
    logic [DATA_W-1:0] rd_word;

    stk_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .TOPIN_W(TOPIN_W)) u_ctrl (
        .op_valid (op_valid),
        .op_code  (op_code),
        .op_slot  (op_slot),
        .tag_in   (tag_in),
        .top_in   (top_in),
        .top_q    (top_q),
        .tags_q   (tags_q),
        .src_idx  (src_idx),
        .tgt_idx  (tgt_idx),
        .data_we  (data_we),
        .copy_sel (copy_sel),
        .tag_we   (tag_we),
        .tag_wv   (tag_wv),
        .top_we   (top_we),
        .top_nxt  (top_nxt),
        .clear_all(clear_all),
        .ret_data (ret_data),
        .flt_empty(flt_empty),
        .flt_full (flt_full)
    );

    stk_tags #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .clear_all(clear_all),
        .tag_we   (tag_we),
        .tag_idx  (tgt_idx),
        .tag_wv   (tag_wv),
        .top_we   (top_we),
        .top_nxt  (top_nxt),
        .tags_q   (tags_q),
        .top_q    (top_q)
    );

    stk_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .data_we (data_we),
        .copy_sel(copy_sel),
        .tgt_idx (tgt_idx),
        .src_idx (src_idx),
        .wr_data (wr_data),
        .rd_word (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data     <= '0;
            rd_valid    <= 1'b0;
            rd_full     <= 1'b0;
            fault_empty <= 1'b0;
            fault_full  <= 1'b0;
        end else begin
            rd_valid    <= ret_data;
            fault_empty <= flt_empty;
            fault_full  <= flt_full;
            if (ret_data) begin
                rd_data <= rd_word;
                rd_full <= tags_q[src_idx];
            end
        end
    end

    assign top_out  = top_q;
    assign tags_out = tags_q;

    logic [PTR_W-1:0] chk_rel, chk_below;
    assign chk_rel   = top_q + op_slot;
    assign chk_below = top_q - STEP;

    // R10
    result_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_valid, fault_empty, fault_full}));

    // R10
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_empty || fault_full) |-> (top_q == $past(top_q) && tags_q == $past(tags_q)));

    // R2
    push_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd1 && !tags_q[chk_below])
        |=> (top_q == $past(top_q) - STEP && tags_q[top_q]));

    // R3
    pop_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd2 && tags_q[top_q])
        |=> (top_q == $past(top_q) + STEP && !tags_q[$past(top_q)] && rd_valid));

    // R5
    read_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd3 && !tags_q[chk_rel]) |=> fault_empty);

    // R8
    exam_nofault_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd6) |=> (rd_valid && !fault_empty && !fault_full));

    // R9
    store_nofull_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd7) |=> !fault_full);

endmodule

// File: tb/fpstk_rstack_test.sv
`timescale 1ns/1ps
module fpstk_rstack_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [2:0]  op_slot = '0;
    logic [63:0] wr_data = '0;
    logic        tag_in = 1'b0;
    logic [31:0] top_in = '0;
    logic [63:0] rd_data;
    logic        rd_valid, rd_full, fault_empty, fault_full;
    logic [2:0]  top_out;
    logic [7:0]  tags_out;

    int n_chk = 0;
    int n_fail = 0;

    logic [63:0] m_data [8];
    logic [7:0]  m_tag;
    logic [2:0]  m_top;

    always #2.5 clk = ~clk;

    fpstk_rstack uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_slot(op_slot), .wr_data(wr_data), .tag_in(tag_in), .top_in(top_in),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_full(rd_full),
        .fault_empty(fault_empty), .fault_full(fault_full),
        .top_out(top_out), .tags_out(tags_out)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd1:       return "R2";
            4'd2:       return "R3";
            4'd3:       return "R4";
            4'd4:       return "R6";
            4'd5:       return "R7";
            4'd6:       return "R8";
            4'd7:       return "R9";
            4'd8, 4'd9: return "R11";
            4'd10:      return "R12";
            default:    return "R10";
        endcase
    endfunction

    task automatic run_op(input logic [3:0] op, input logic [2:0] slot,
                          input logic [63:0] wd, input logic tv,
                          input logic [31:0] ti, input string req);
        logic        efe = 1'b0;
        logic        eff = 1'b0;
        logic        erv = 1'b0;
        logic        ert = 1'b0;
        logic [63:0] erd = '0;
        logic [2:0]  rel = m_top + slot;
        logic [2:0]  dn  = m_top - 3'd1;
        case (op)
            4'd1: if (m_tag[dn]) eff = 1'b1;
                  else begin m_top = dn; m_data[dn] = wd; m_tag[dn] = 1'b1; end
            4'd2: if (!m_tag[m_top]) efe = 1'b1;
                  else begin
                      erv = 1'b1; erd = m_data[m_top]; ert = 1'b1;
                      m_tag[m_top] = 1'b0; m_top = m_top + 3'd1;
                  end
            4'd3: if (!m_tag[rel]) efe = 1'b1;
                  else begin erv = 1'b1; erd = m_data[rel]; ert = 1'b1; end
            4'd4: if (m_tag[rel]) eff = 1'b1;
                  else begin m_data[rel] = wd; m_tag[rel] = 1'b1; end
            4'd5: if (!m_tag[rel]) efe = 1'b1;
                  else begin erv = 1'b1; erd = m_data[rel]; ert = 1'b1; m_data[rel] = wd; end
            4'd6: begin erv = 1'b1; erd = m_data[rel]; ert = m_tag[rel]; end
            4'd7: if (!m_tag[m_top]) efe = 1'b1;
                  else begin
                      erv = 1'b1; erd = m_data[m_top]; ert = 1'b1;
                      m_data[rel] = m_data[m_top]; m_tag[rel] = 1'b1;
                  end
            4'd8: m_tag[slot] = tv;
            4'd9: m_top = ti[2:0];
            4'd10: begin m_tag = '0; m_top = '0; end
            default: ;
        endcase
        op_valid = 1'b1; op_code = op; op_slot = slot;
        wr_data = wd; tag_in = tv; top_in = ti;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        chk(req, "fault_empty", 64'(fault_empty), 64'(efe));
        chk(req, "fault_full", 64'(fault_full), 64'(eff));
        chk(req, "rd_valid", 64'(rd_valid), 64'(erv));
        chk(req, "top_out", 64'(top_out), 64'(m_top));
        chk(req, "tags_out", 64'(tags_out), 64'(m_tag));
        if (erv) begin
            chk(req, "rd_data", rd_data, erd);
            chk(req, "rd_full", 64'(rd_full), 64'(ert));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_data[i] = '0;
        m_tag = '0;
        m_top = '0;
        void'($urandom(32'd20041));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "tags_out", 64'(tags_out), 64'h0);
        chk("R1", "top_out", 64'(top_out), 64'h0);
        chk("R1", "rd_valid", 64'(rd_valid), 64'h0);
        chk("R1", "faults", 64'({fault_empty, fault_full}), 64'h0);

        // R2: fill all eight, then one more push faults full
        for (int i = 0; i < 8; i++)
            run_op(4'd1, 3'd0, 64'hA5A5_0000_0000_0000 + 64'(i), 1'b0, 32'd0, "R2");
        run_op(4'd1, 3'd0, 64'hDEAD_BEEF_0000_0009, 1'b0, 32'd0, "R2");
        // R10: pulse lasts one cycle
        run_op(4'd0, 3'd0, 64'd0, 1'b0, 32'd0, "R10");
        // R4 / R8 / R7 / R6 on a full stack
        run_op(4'd3, 3'd3, 64'd0, 1'b0, 32'd0, "R4");
        run_op(4'd6, 3'd5, 64'd0, 1'b0, 32'd0, "R8");
        run_op(4'd5, 3'd2, 64'h1111_2222_3333_4444, 1'b0, 32'd0, "R7");
        run_op(4'd4, 3'd1, 64'h5555_6666_7777_8888, 1'b0, 32'd0, "R6");
        // R9: store onto a full slot does not fault
        run_op(4'd7, 3'd4, 64'd0, 1'b0, 32'd0, "R9");
        // R3: drain everything
        for (int i = 0; i < 8; i++)
            run_op(4'd2, 3'd0, 64'd0, 1'b0, 32'd0, "R3");
        // R5: empty faults
        run_op(4'd2, 3'd0, 64'd0, 1'b0, 32'd0, "R5");
        run_op(4'd3, 3'd6, 64'd0, 1'b0, 32'd0, "R5");
        run_op(4'd6, 3'd6, 64'd0, 1'b0, 32'd0, "R8");
        run_op(4'd5, 3'd1, 64'h9999, 1'b0, 32'd0, "R7");
        run_op(4'd7, 3'd2, 64'd0, 1'b0, 32'd0, "R9");
        // R11: tag write and pointer load with junk upper bits
        run_op(4'd8, 3'd6, 64'd0, 1'b1, 32'd0, "R11");
        run_op(4'd9, 3'd0, 64'd0, 1'b0, 32'hABCD_EF0D, "R11");
        run_op(4'd3, 3'd1, 64'd0, 1'b0, 32'd0, "R11");
        // R6: write into an empty slot fills it
        run_op(4'd4, 3'd0, 64'hCAFE_F00D_0000_0001, 1'b0, 32'd0, "R6");
        run_op(4'd3, 3'd0, 64'd0, 1'b0, 32'd0, "R6");
        // R12: clear
        run_op(4'd10, 3'd0, 64'd0, 1'b0, 32'd0, "R12");

        for (int i = 0; i < 700; i++) begin
            int unsigned r = $urandom % 20;
            logic [3:0] op;
            if      (r < 4)  op = 4'd1;
            else if (r < 7)  op = 4'd2;
            else if (r < 9)  op = 4'd3;
            else if (r < 11) op = 4'd4;
            else if (r < 13) op = 4'd5;
            else if (r < 14) op = 4'd6;
            else if (r < 16) op = 4'd7;
            else if (r < 17) op = 4'd8;
            else if (r < 18) op = 4'd9;
            else if (r < 19) op = 4'd0;
            else             op = ($urandom % 4 == 0) ? 4'd10 : 4'd1;
            run_op(op, 3'($urandom), {$urandom, $urandom}, 1'($urandom),
                   $urandom, req_of(op));
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule